// File: doc/BRIEF.md
# Quadrature Encoder Delta and Edge-Time Capture

This block turns the two phase signals of an incremental encoder into the two numbers a speed estimator of the improved M/T kind needs once per control period. The first is the signed number of quadrature steps seen since the previous sampling strobe. The second is the time, measured from that strobe, at which the latest step arrived. The phase inputs are taken in only on a sample-enable pulse (nominally 15 MHz). Each pulse shifts them through two synchroniser stages before they reach a four-counts-per-cycle decoder.

A periodic strobe, normally the modulator interrupt, ends a period. In that single cycle the running step count is copied, sign-extended to 16 bits, into the position output and the counter restarts. The edge-time output receives the 12-bit time stamp of the last step, counted in tick-enable units and held at 4095 once it gets there. If no step arrived, it receives a flag in bit 15 instead. Both outputs then stay fixed until the next strobe. Software adds the deltas into an absolute position.

Top module: `enc_mt_capture`

## Requirements
- R1: While rst_n is low, pos_q is 0x0000 and time_q is 0x8000.
- R2: enc_a/enc_b are taken in only in cycles with smp_en high and pass two register stages. A change present at the first such sample is counted on the third smp_en cycle.
- R3: Taking {enc_a,enc_b}, the order 00→10→11→01→00 is forward and adds +1 per transition. The opposite order adds −1. A full cycle gives four counts.
- R4: A sample pair in which both phase bits differ, or neither does, adds no count.
- R5: In a cycle with strobe high, pos_q takes the 12-bit two's complement step count of the ending period, with bit 11 copied into bits 15..12. The range is −2048 to +2047. The counter restarts in that same cycle.
- R6: A step counted in a strobe cycle belongs to the new period. It counts 1 there, and the new period's edge time becomes 0.
- R7: An edge timer restarts at 0 on strobe and advances by one on each tick_en cycle, holding at 4095. At strobe, time_q[11:0] takes the timer value sampled at the last counted step of the ending period, and time_q[15] is 0.
- R8: If the ending period had no counted step, time_q becomes 0x8000. time_q[14:12] are always 0.
- R9: pos_q and time_q change only in strobe cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Input sample enable (15 MHz rate) |
| tick_en | input | 1 | Edge-timer time unit enable |
| strobe | input | 1 | End-of-period capture strobe |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| pos_q | output | 16 | Sign-extended step delta of the last period |
| time_q | output | 16 | Bit 15 no-edge flag, bits 11..0 last edge time |

## Verification
The hardest situations to reach are those where a counted step lands exactly on the strobe, or one sample before it. This happens three sample enables after the pin change, so it cannot be seen directly at the ports. The bench switches sample-enable to every cycle and places the one-cycle strobe a counted number of edges after the pin change. The delta then shows up in one period or the next, and the R2 and R6 checks tell which. Timer saturation needs a long silent period followed by a single step, and the ±2047/−2048 limits need long unbroken runs in one direction.

// File: rtl/enc_mt_capture.sv
module enc_mt_capture #(
  parameter int CNT_W  = 12,
  parameter int TIME_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             tick_en,
  input  logic             strobe,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic [OUT_W-1:0] pos_q,
  output logic [OUT_W-1:0] time_q
);
  localparam int PAD_W = OUT_W - 1 - TIME_W;
  localparam logic [TIME_W-1:0] T_MAX = '1;

  logic [1:0] sy1, sy2, held;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; held <= '0;
    end else if (smp_en) begin
      sy1  <= {enc_a, enc_b};
      sy2  <= sy1;
      held <= sy2;
    end
  end

  // gray to binary phase index: 00->0, 01->1, 11->2, 10->3
  logic [1:0] ph_new, ph_old, ph_d;
  assign ph_new = {sy2[1], sy2[1] ^ sy2[0]};
  assign ph_old = {held[1], held[1] ^ held[0]};
  assign ph_d   = ph_new - ph_old;

  logic fwd, rev, moved;
  assign fwd   = smp_en && (ph_d == 2'd3);
  assign rev   = smp_en && (ph_d == 2'd1);
  assign moved = fwd | rev;

  logic [CNT_W-1:0] step, cnt;
  assign step = fwd ? CNT_W'(1) : (rev ? '1 : '0);

  logic [TIME_W-1:0] tmr, last_t;
  logic              seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      tmr    <= '0;
      last_t <= '0;
      seen   <= 1'b0;
      pos_q  <= '0;
      time_q <= {1'b1, {(OUT_W-1){1'b0}}};
    end else if (strobe) begin
      pos_q  <= {{(OUT_W-CNT_W){cnt[CNT_W-1]}}, cnt};
      time_q <= seen ? {1'b0, {PAD_W{1'b0}}, last_t} : {1'b1, {(OUT_W-1){1'b0}}};
      cnt    <= step;
      tmr    <= '0;
      last_t <= '0;
      seen   <= moved;
    end else begin
      cnt <= cnt + step;
      if (moved) begin
        last_t <= tmr;
        seen   <= 1'b1;
      end
      if (tick_en && tmr != T_MAX) tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/enc_mt_capture_chk.sv
module enc_mt_capture_chk #(
  parameter int CNT_W  = 12,
  parameter int TIME_W = 12,
  parameter int OUT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_en,
  input logic             tick_en,
  input logic             strobe,
  input logic [1:0]       sy2,
  input logic [1:0]       held,
  input logic [CNT_W-1:0] cnt,
  input logic [TIME_W-1:0] tmr,
  input logic [OUT_W-1:0] pos_q,
  input logic [OUT_W-1:0] time_q
);
  a_r1_reset_values: assert property (@(posedge clk)
    !rst_n |=> (pos_q == '0 && time_q == {1'b1, {(OUT_W-1){1'b0}}}));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(pos_q) && $stable(time_q)));

  a_r8_flag_clean: assert property (@(posedge clk) disable iff (!rst_n)
    time_q[OUT_W-1] |-> (time_q[OUT_W-2:0] == '0));

  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    time_q[OUT_W-2:TIME_W] == '0);

  a_r5_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pos_q[OUT_W-1:CNT_W-1]) == 0) ||
    ($countones(pos_q[OUT_W-1:CNT_W-1]) == OUT_W-CNT_W+1));

  a_r4_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !strobe && ((sy2 ^ held) == 2'b11 || sy2 == held)) |=> (cnt == $past(cnt)));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr == '1 && !strobe) |=> (tmr == '1));
endmodule

bind enc_mt_capture enc_mt_capture_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .tick_en(tick_en), .strobe(strobe),
  .sy2(sy2), .held(held), .cnt(cnt), .tmr(tmr), .pos_q(pos_q), .time_q(time_q)
);

// File: tb/test_enc_mt_capture.sv
`timescale 1ns/1ps
module test_enc_mt_capture;
  logic clk = 0, rst_n = 0, strobe = 0, enc_a = 0, enc_b = 0, fast = 0;
  logic [1:0] div = 0;
  logic smp_en, tick_en;
  logic [15:0] pos_q, time_q;
  int checks = 0, errors = 0, ph = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(negedge clk) div <= div + 2'd1;
  assign smp_en  = fast | (div == 2'd0);
  assign tick_en = ~div[0];

  enc_mt_capture i_enc_mt_capture (.clk(clk), .rst_n(rst_n), .smp_en(smp_en), .tick_en(tick_en),
    .strobe(strobe), .enc_a(enc_a), .enc_b(enc_b), .pos_q(pos_q), .time_q(time_q));

  // behavioural reference model
  int h0 = 0, h1 = 0, h2 = 0, m_tmr = 0, m_last = 0;
  bit m_seen = 0;
  logic [11:0] m_cnt = 0;
  logic [15:0] m_pos = 0, m_time = 16'h8000;

  function automatic int pidx(int v);
    case (v) 0: return 0; 2: return 1; 3: return 2; default: return 3; endcase
  endfunction

  always @(posedge clk) begin
    int st, d;
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; m_tmr = 0; m_last = 0; m_seen = 0; m_cnt = 0;
      m_pos = 0; m_time = 16'h8000;
    end else begin
      st = 0;
      if (smp_en) begin
        d = (pidx(h1) - pidx(h2) + 4) % 4;
        if (d == 1) st = 1; else if (d == 3) st = -1;
        h2 = h1; h1 = h0; h0 = {enc_a, enc_b};
      end
      if (strobe) begin
        m_pos  = {{4{m_cnt[11]}}, m_cnt};
        m_time = m_seen ? 16'(m_last) : 16'h8000;
        m_cnt  = 12'(st);
        m_seen = (st != 0);
        m_last = 0; m_tmr = 0;
      end else begin
        m_cnt = m_cnt + 12'(st);
        if (st != 0) begin m_seen = 1; m_last = m_tmr; end
        if (tick_en && m_tmr < 4095) m_tmr++;
      end
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (pos_q !== m_pos) begin errors++; $display("FAIL R5 model pos_q got %h exp %h", pos_q, m_pos); end
    checks++;
    if (time_q !== m_time) begin errors++; $display("FAIL R7 model time_q got %h exp %h", time_q, m_time); end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin errors++; $display("FAIL %s got %h exp %h", tag, got, exp); end
  endtask

  task automatic settle(); repeat (16) @(negedge clk); endtask
  task automatic pulse(); @(negedge clk) strobe = 1; @(negedge clk) strobe = 0; endtask
  task automatic drive_ph(int p);
    case (p) 0: {enc_a, enc_b} = 2'b00; 1: {enc_a, enc_b} = 2'b10;
             2: {enc_a, enc_b} = 2'b11; default: {enc_a, enc_b} = 2'b01; endcase
  endtask
  task automatic move(int dir, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ph = (ph + dir + 4) % 4; drive_ph(ph);
      repeat (15) @(negedge clk);
    end
    settle();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 pos_q in reset", pos_q, 16'h0000);
    chk("R1 time_q in reset", time_q, 16'h8000);
    rst_n = 1;
    settle(); pulse();
    chk("R8 empty period pos", pos_q, 16'h0000);
    chk("R8 empty period time", time_q, 16'h8000);

    move(1, 4); pulse();
    chk("R3 forward four", pos_q, 16'h0004);
    chk("R7 edge seen flag", {15'd0, time_q[15]}, 16'h0000);

    move(-1, 5);
    chk("R9 hold during motion", pos_q, 16'h0004);
    pulse();
    chk("R3 R5 reverse five", pos_q, 16'hFFFB);

    @(negedge clk); ph = (ph + 2) % 4; drive_ph(ph); settle(); pulse();
    chk("R4 double jump pos", pos_q, 16'h0000);
    chk("R4 double jump time", time_q, 16'h8000);

    // R2: strobe one sample before the step is counted
    fast = 1; settle(); pulse();
    @(negedge clk); ph = (ph + 1) % 4; drive_ph(ph);
    @(posedge clk); @(negedge clk) strobe = 1; @(negedge clk) strobe = 0;
    chk("R2 not yet counted", pos_q, 16'h0000);
    settle(); pulse();
    chk("R2 counted next period", pos_q, 16'h0001);

    // R6: strobe coincides with the counted step
    @(negedge clk); ph = (ph + 1) % 4; drive_ph(ph);
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk) strobe = 1;
    @(negedge clk) strobe = 0;
    chk("R6 old period empty", pos_q, 16'h0000);
    settle(); pulse();
    chk("R6 step in new period", pos_q, 16'h0001);
    chk("R6 edge time zero", time_q, 16'h0000);
    fast = 0;

    pulse(); repeat (9000) @(negedge clk);
    move(1, 1); pulse();
    chk("R7 saturated time", time_q, 16'h0FFF);

    move(1, 2047); pulse();
    chk("R5 max positive", pos_q, 16'h07FF);
    move(-1, 2048); pulse();
    chk("R5 max negative", pos_q, 16'hF800);

    settle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog R9 got hung exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule